// File: doc/BRIEF.md
# DRAM Bank Command Selector

This block is the per-bank decision unit of a DRAM controller. It remembers whether its bank is idle (precharged) or has a row open, and if so which row. Each cycle it looks at the request the scheduler presents at the head of this bank's queue and proposes the next DRAM command. The proposal can be an activate, a precharge, a plain column read or write, a column access with auto-precharge, or nothing.

The page policy is fixed at elaboration by a parameter. Open keeps rows open. Closed always closes the row after the access. The two adaptive variants use scheduler hints to decide whether the access should carry auto-precharge: one hint says more requests are pending for the bank, the other says one of them hits the open row.

The proposal is registered and carries its own valid strobe. The controller reports back the command it actually issued. Only that report moves the bank state, so a proposal that is not taken changes nothing. Timing-rule checks, arbitration between banks, refresh and power management belong to other blocks.

Top module: `bank_cmd_sel`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `prop_cmd` is NOP (0), `prop_valid` is 0, both error flags are 0, and the bank is precharged.
- R2: When `sleep` or `block` is 1, or `req_valid` is 0, the next `prop_cmd` is NOP and neither error flag is raised.
- R3: With the bank precharged and a request taken (`req_valid`=1, `sleep`=0, `block`=0), the next `prop_cmd` is ACT (1) under every policy, whatever `req_kind` is.
- R4: Policy 0 (open), bank activated: a request whose `req_row` equals the open row gives RD (3) for a read or WR (4) for a write; any other row gives PRE (2).
- R5: Policy 1 (closed), bank activated: a request gives RDA (5) for a read or WRA (6) for a write, whatever its row.
- R6: Policy 2 (open-adaptive), bank activated: on a row hit the result is RDA/WRA when `hint_more_req`=1 and `hint_more_hit`=0, and RD/WR otherwise; a row miss gives PRE.
- R7: Policy 3 (closed-adaptive), bank activated, row hit: the result is RD/WR when `hint_more_hit`=1, otherwise RDA/WRA.
- R8: Policy 3, bank activated, a row miss on a taken request: the next cycle shows `err_miss`=1 and `prop_cmd`=NOP.
- R9: `req_kind` encodes 2'b01 read and 2'b10 write. When a column command would be chosen and `req_kind` is 00 or 11, the next cycle shows `err_kind`=1 and `prop_cmd`=NOP.
- R10: An issued ACT (`iss_valid`=1, `iss_cmd`=1) activates the bank and stores `iss_row` as the open row. An issued PRE, RDA or WRA precharges the bank. Issued NOP, RD and WR leave the state as it is. Every decision made in a cycle uses the state held before that cycle's issue report.
- R11: `prop_valid` is 1 exactly when the registered `prop_cmd` is not NOP. Both follow the inputs one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Head request present for this bank |
| req_kind | input | 2 | 01 read, 10 write, other values illegal |
| req_row | input | ROW_W | Row addressed by the head request |
| hint_more_req | input | 1 | Further requests pending for this bank |
| hint_more_hit | input | 1 | A further pending request hits the open row |
| sleep | input | 1 | Bank asleep, take no request |
| block | input | 1 | Bank blocked, take no request |
| iss_valid | input | 1 | A command was issued to this bank |
| iss_cmd | input | 3 | Issued command code |
| iss_row | input | ROW_W | Row carried by the issued command |
| prop_cmd | output | 3 | Proposed command: 0 NOP, 1 ACT, 2 PRE, 3 RD, 4 WR, 5 RDA, 6 WRA |
| prop_valid | output | 1 | Proposal is not NOP |
| err_kind | output | 1 | Illegal request type at a column decision |
| err_miss | output | 1 | Row miss under closed-adaptive policy |

## Verification
A wrong activated/precharged bit or a stale open row cannot be read at the ports directly. It shows up one clock later as the wrong class of proposal: ACT where a column command or PRE was due, or the reverse, or a hit/miss judged against the wrong row. The bench runs all four policies side by side under mixed stimulus. It compares every output on every cycle, so a state error appears at the first taken request after the faulty issue report.

// File: rtl/bank_cmd_sel.sv
module bank_cmd_sel #(
  parameter int ROW_W  = 14,
  parameter int POLICY = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic [ROW_W-1:0] req_row,
  input  logic             hint_more_req,
  input  logic             hint_more_hit,
  input  logic             sleep,
  input  logic             block,
  input  logic             iss_valid,
  input  logic [2:0]       iss_cmd,
  input  logic [ROW_W-1:0] iss_row,
  output logic [2:0]       prop_cmd,
  output logic             prop_valid,
  output logic             err_kind,
  output logic             err_miss
);
  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_PRE = 3'd2,
                         C_RD  = 3'd3, C_WR  = 3'd4, C_RDA = 3'd5, C_WRA = 3'd6;
  localparam bit OPEN_HIT_PLAIN = (POLICY == 0);
  localparam bit MISS_PRE       = (POLICY == 0) || (POLICY == 2);

  logic             act_q;
  logic [ROW_W-1:0] open_row;

  logic       taken, hit, is_rd, kind_ok, want_auto;
  logic [2:0] col_cmd, nxt_cmd;
  logic       nxt_ekind, nxt_emiss;

  assign taken   = req_valid && !sleep && !block;
  assign hit     = (req_row == open_row);
  assign is_rd   = (req_kind == 2'b01);
  assign kind_ok = (req_kind == 2'b01) || (req_kind == 2'b10);

  always_comb begin
    case (POLICY)
      1:       want_auto = 1'b1;
      2:       want_auto = hint_more_req && !hint_more_hit;
      3:       want_auto = !hint_more_hit;
      default: want_auto = 1'b0;
    endcase
  end

  assign col_cmd = want_auto ? (is_rd ? C_RDA : C_WRA) : (is_rd ? C_RD : C_WR);

  always_comb begin
    nxt_cmd   = C_NOP;
    nxt_ekind = 1'b0;
    nxt_emiss = 1'b0;
    if (taken) begin
      if (!act_q) begin
        nxt_cmd = C_ACT;
      end else if (hit || POLICY == 1) begin
        if (kind_ok) nxt_cmd = col_cmd;
        else         nxt_ekind = 1'b1;
      end else if (MISS_PRE) begin
        nxt_cmd = C_PRE;
      end else begin
        nxt_emiss = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prop_cmd   <= C_NOP;
      prop_valid <= 1'b0;
      err_kind   <= 1'b0;
      err_miss   <= 1'b0;
    end else begin
      prop_cmd   <= nxt_cmd;
      prop_valid <= taken && !nxt_ekind && !nxt_emiss;
      err_kind   <= nxt_ekind;
      err_miss   <= nxt_emiss;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q    <= 1'b0;
      open_row <= '0;
    end else if (iss_valid) begin
      case (iss_cmd)
        C_ACT: begin
          act_q    <= 1'b1;
          open_row <= iss_row;
        end
        C_PRE, C_RDA, C_WRA: act_q <= 1'b0;
        default: ;
      endcase
    end
  end

  logic unused_plain;
  assign unused_plain = OPEN_HIT_PLAIN;
endmodule

// File: rtl/bank_cmd_sel_sva.sv
module bank_cmd_sel_sva #(
  parameter int ROW_W  = 14,
  parameter int POLICY = 0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [1:0]       req_kind,
  input logic [ROW_W-1:0] req_row,
  input logic             sleep,
  input logic             block,
  input logic             iss_valid,
  input logic [2:0]       iss_cmd,
  input logic [ROW_W-1:0] iss_row,
  input logic [2:0]       prop_cmd,
  input logic             prop_valid,
  input logic             err_kind,
  input logic             err_miss,
  input logic             act_q,
  input logic [ROW_W-1:0] open_row
);
  a_r2_idle_nop: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep || block || !req_valid) |=> (prop_cmd == 3'd0 && !err_kind && !err_miss));

  a_r3_act_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_q && req_valid && !sleep && !block) |=> (prop_cmd == 3'd1));

  a_r5_closed_no_plain: assert property (@(posedge clk) disable iff (!rst_n)
    (POLICY == 1) |-> !(prop_cmd inside {3'd2, 3'd3, 3'd4}));

  a_r8_miss_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (POLICY == 3 && act_q && req_valid && !sleep && !block && req_row != open_row)
      |=> (err_miss && prop_cmd == 3'd0));

  a_r9_kind_flag: assert property (@(posedge clk) disable iff (!rst_n)
    err_kind |-> (prop_cmd == 3'd0 && $past(req_kind) != 2'b01 && $past(req_kind) != 2'b10));

  a_r10_act_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_cmd == 3'd1) |=> (act_q && open_row == $past(iss_row)));

  a_r10_close: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_cmd inside {3'd2, 3'd5, 3'd6}) |=> !act_q);

  a_r11_valid_match: assert property (@(posedge clk) disable iff (!rst_n)
    prop_valid == (prop_cmd != 3'd0));
endmodule

bind bank_cmd_sel bank_cmd_sel_sva #(.ROW_W(ROW_W), .POLICY(POLICY)) u_sva (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
  .req_row(req_row), .sleep(sleep), .block(block), .iss_valid(iss_valid),
  .iss_cmd(iss_cmd), .iss_row(iss_row), .prop_cmd(prop_cmd),
  .prop_valid(prop_valid), .err_kind(err_kind), .err_miss(err_miss),
  .act_q(act_q), .open_row(open_row));

// File: tb/bank_cmd_sel_test.sv
module bank_cmd_sel_test;
  localparam int RW = 4;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic          req_valid = 0, hint_more_req = 0, hint_more_hit = 0;
  logic          sleep = 0, block = 0, iss_valid = 0;
  logic [1:0]    req_kind = 2'b01;
  logic [RW-1:0] req_row = '0, iss_row = '0;
  logic [2:0]    iss_cmd = 3'd0;

  logic [2:0] o_cmd [4];
  logic       o_val [4];
  logic       o_ek  [4];
  logic       o_em  [4];

  bank_cmd_sel #(.ROW_W(RW), .POLICY(0)) uut (.clk, .rst_n, .req_valid, .req_kind, .req_row,
    .hint_more_req, .hint_more_hit, .sleep, .block, .iss_valid, .iss_cmd, .iss_row,
    .prop_cmd(o_cmd[0]), .prop_valid(o_val[0]), .err_kind(o_ek[0]), .err_miss(o_em[0]));
  bank_cmd_sel #(.ROW_W(RW), .POLICY(1)) uut_c (.clk, .rst_n, .req_valid, .req_kind, .req_row,
    .hint_more_req, .hint_more_hit, .sleep, .block, .iss_valid, .iss_cmd, .iss_row,
    .prop_cmd(o_cmd[1]), .prop_valid(o_val[1]), .err_kind(o_ek[1]), .err_miss(o_em[1]));
  bank_cmd_sel #(.ROW_W(RW), .POLICY(2)) uut_oa (.clk, .rst_n, .req_valid, .req_kind, .req_row,
    .hint_more_req, .hint_more_hit, .sleep, .block, .iss_valid, .iss_cmd, .iss_row,
    .prop_cmd(o_cmd[2]), .prop_valid(o_val[2]), .err_kind(o_ek[2]), .err_miss(o_em[2]));
  bank_cmd_sel #(.ROW_W(RW), .POLICY(3)) uut_ca (.clk, .rst_n, .req_valid, .req_kind, .req_row,
    .hint_more_req, .hint_more_hit, .sleep, .block, .iss_valid, .iss_cmd, .iss_row,
    .prop_cmd(o_cmd[3]), .prop_valid(o_val[3]), .err_kind(o_ek[3]), .err_miss(o_em[3]));

  int checks = 0, errors = 0;

  // Reference model: per policy, bank open flag and open row
  bit            m_open [4];
  int            m_row  [4];
  int            e_cmd  [4];
  bit            e_ek   [4];
  bit            e_em   [4];
  string         e_tag  [4];
  bit            last_issue;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < 4; p++) begin
        m_open[p] = 0; m_row[p] = 0; e_cmd[p] = 0; e_ek[p] = 0; e_em[p] = 0; e_tag[p] = "R1";
      end
      last_issue = 0;
    end else begin
      for (int p = 0; p < 4; p++) begin
        int  cmd;
        bit  rd, good, hitr, autop;
        string tg;
        cmd = 0; e_ek[p] = 0; e_em[p] = 0;
        rd = (req_kind == 2'b01);
        good = (req_kind == 2'b01 || req_kind == 2'b10);
        hitr = (int'(req_row) == m_row[p]);
        if (!req_valid || sleep || block) tg = "R2";
        else if (!m_open[p]) begin cmd = 1; tg = "R3"; end
        else begin
          tg = (p == 0) ? "R4" : (p == 1) ? "R5" : (p == 2) ? "R6" : "R7";
          if (!hitr && p != 1) begin
            if (p == 3) begin e_em[p] = 1; tg = "R8"; end
            else cmd = 2;
          end else begin
            autop = (p == 1) || (p == 2 && hint_more_req && !hint_more_hit)
                  || (p == 3 && !hint_more_hit);
            if (!good) begin e_ek[p] = 1; tg = "R9"; end
            else cmd = rd ? (autop ? 5 : 3) : (autop ? 6 : 4);
          end
        end
        if (last_issue) tg = {tg, "/R10"};
        e_cmd[p] = cmd; e_tag[p] = tg;
        // R10: issue report moves the state after this cycle's decision
        if (iss_valid) begin
          if (iss_cmd == 3'd1) begin m_open[p] = 1; m_row[p] = int'(iss_row); end
          else if (iss_cmd == 3'd2 || iss_cmd == 3'd5 || iss_cmd == 3'd6) m_open[p] = 0;
        end
      end
      last_issue = iss_valid;
    end
  end

  task automatic compare_all();
    for (int p = 0; p < 4; p++) begin
      check(e_tag[p], int'(o_cmd[p]), e_cmd[p]);
      check("R11", int'(o_val[p]), int'(e_cmd[p] != 0));
      check({e_tag[p], " err_kind"}, int'(o_ek[p]), int'(e_ek[p]));
      check({e_tag[p], " err_miss"}, int'(o_em[p]), int'(e_em[p]));
    end
  endtask

  task automatic drive(input bit v, input logic [1:0] k, input int row, input bit mr, input bit mh,
                       input bit sl, input bit bl, input bit iv, input int ic, input int ir);
    req_valid = v; req_kind = k; req_row = RW'(row); hint_more_req = mr; hint_more_hit = mh;
    sleep = sl; block = bl; iss_valid = iv; iss_cmd = 3'(ic); iss_row = RW'(ir);
  endtask

  task automatic step(input bit v, input logic [1:0] k, input int row, input bit mr, input bit mh,
                      input bit sl, input bit bl, input bit iv, input int ic, input int ir);
    drive(v, k, row, mr, mh, sl, bl, iv, ic, ir);
    @(negedge clk);
    compare_all();
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int p = 0; p < 4; p++) begin
      check("R1 cmd", int'(o_cmd[p]), 0);
      check("R1 valid", int'(o_val[p]), 0);
      check("R1 errs", int'(o_ek[p] | o_em[p]), 0);
    end
    rst_n = 1;
    @(negedge clk);
    for (int p = 0; p < 4; p++) check("R1 after release", int'(o_cmd[p]), 0);
    // R3 then R10: take request, issue ACT row 5
    step(1, 2'b01, 5, 0, 0, 0, 0, 0, 0, 0);
    step(1, 2'b01, 5, 0, 0, 0, 0, 1, 1, 5);
    // R4-R7 hit read, various hints
    step(1, 2'b01, 5, 0, 0, 0, 0, 0, 0, 0);
    step(1, 2'b10, 5, 1, 0, 0, 0, 0, 0, 0);
    step(1, 2'b10, 5, 1, 1, 0, 0, 0, 0, 0);
    // R2 sleep and block
    step(1, 2'b01, 5, 0, 0, 1, 0, 0, 0, 0);
    step(1, 2'b01, 5, 0, 0, 0, 1, 0, 0, 0);
    step(0, 2'b01, 5, 0, 0, 0, 0, 0, 0, 0);
    // R8 miss, R9 bad kind
    step(1, 2'b01, 9, 0, 0, 0, 0, 0, 0, 0);
    step(1, 2'b11, 5, 0, 0, 0, 0, 0, 0, 0);
    step(1, 2'b00, 9, 0, 0, 0, 0, 0, 0, 0);
    // R10: issued RD keeps open, then RDA closes
    step(1, 2'b01, 5, 0, 0, 0, 0, 1, 3, 0);
    step(1, 2'b01, 5, 0, 0, 0, 0, 1, 5, 0);
    step(1, 2'b00, 5, 0, 0, 0, 0, 0, 0, 0);
    // mixed stimulus
    for (int i = 0; i < 4000; i++) begin
      int rv;
      rv = int'($urandom % 100);
      step(rv < 80, ($urandom % 10 == 0) ? 2'(($urandom % 2) * 3) : 2'(1 + $urandom % 2),
           int'($urandom % 4), bit'($urandom % 2), bit'($urandom % 2),
           ($urandom % 10) == 0, ($urandom % 10) == 0,
           bit'($urandom % 2), int'($urandom % 7), int'($urandom % 4));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule